// File: doc/BRIEF.md
# Ping-Pong Operand Buffer with Asymmetric Ports

This block holds operand data for one processing array. It has six storage banks grouped into two sets of three. A narrow port, used for DMA transfers, and a wide port, used by the array, reach the same storage. At any time the narrow port sees one set and the wide port sees the other. A single swap strobe exchanges the two sets. DMA can therefore load the next batch of operands while the array computes on the batch loaded before.

Each bank appears as 64 words of 32 bits on the narrow port and as 32 words of 64 bits on the wide port. Both views cover the same 256 bytes. Each wide word packs two adjacent narrow words, so a DMA engine can fill a bank with narrow writes and the array can read it back in wide words, or the other way round. Both ports register their read data, and the read data holds until the next read on the same port.

Top module: `opnd_pingpong_buf`

## Requirements
- R1: During and directly after reset, both read-data outputs are zero and the set selector `sel_o` is 0.
- R2: `sel_o` toggles at every clock edge where `swap_i` is high and holds otherwise. Port N uses set `sel_o` and port W uses the other set. An access in the same cycle as a swap uses the selector value from before the swap.
- R3: A read on either port (enable high, write-enable low) returns its data on the read-data output in the cycle after the request.
- R4: Wide word k of a bank is built from narrow words 2k and 2k+1 of that bank. Narrow word 2k is bits 31:0 and narrow word 2k+1 is bits 63:32. This holds for data written through either port.
- R5: A read-data output changes only after a read on its own port. Idle cycles, writes and traffic on the other port leave it unchanged.
- R6: Bank codes 0 to 2 select a bank within a set. Bank code 3 selects nothing: a write with code 3 changes no storage, and a read with code 3 returns zero.
- R7: Both ports can access their own sets in the same cycle, reads and writes in any mix, and neither port disturbs the other.
- R8: All 1536 bytes (2 sets x 3 banks x 64 narrow words x 4 bytes) can be addressed separately, and each location keeps its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_i | input | 1 | Exchange the sets seen by the two ports |
| sel_o | output | 1 | Set currently owned by port N |
| n_en | input | 1 | Port N access enable |
| n_we | input | 1 | Port N write (1) or read (0) |
| n_bank | input | 2 | Port N bank code within its set |
| n_addr | input | 6 | Port N word address (32-bit words) |
| n_wdata | input | 32 | Port N write data |
| n_rdata | output | 32 | Port N read data |
| w_en | input | 1 | Port W access enable |
| w_we | input | 1 | Port W write (1) or read (0) |
| w_bank | input | 2 | Port W bank code within its set |
| w_addr | input | 5 | Port W word address (64-bit words) |
| w_wdata | input | 64 | Port W write data |
| w_rdata | output | 64 | Port W read data |

## Verification
The hardest case to reach from the ports is data crossing between the two views. A value written through one port can only be read back through the other port after a swap, when the set has changed owner. The stimulus fills one set through the narrow port and the other set through the wide port in the same cycles. It then swaps and reads each set back through the opposite port. It also places a swap in the same cycle as a read, to show that the read still uses the old selector. A long random phase follows with random swaps, bank code 3 included and both ports busy. It is compared word by word against a model that tracks the byte layout of every bank.

// File: rtl/opbuf_pkg.sv
package opbuf_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   function automatic int min1_clog2(input int v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction

   function automatic op_e decode_op(input logic en, input logic we);
      if (!en)    return OP_IDLE;
      else if (we) return OP_WRITE;
      else        return OP_READ;
   endfunction

endpackage

// File: rtl/opbuf_bank.sv
module opbuf_bank #(
   parameter  int A_W   = 32,
   parameter  int A_D   = 64,
   parameter  int RATIO = 2,
   localparam int B_W   = A_W * RATIO,
   localparam int R_D   = A_D / RATIO,
   localparam int AA_W  = $clog2(A_D),
   localparam int RA_W  = $clog2(R_D),
   localparam int RLOG  = $clog2(RATIO)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            a_rd,
   input  logic            a_wr,
   input  logic [AA_W-1:0] a_addr,
   input  logic [A_W-1:0]  a_wdata,
   output logic [A_W-1:0]  a_rdata,
   input  logic            b_rd,
   input  logic            b_wr,
   input  logic [RA_W-1:0] b_addr,
   input  logic [B_W-1:0]  b_wdata,
   output logic [B_W-1:0]  b_rdata
);

   initial begin : elab_chk
      assert (RATIO >= 2 && (1 << RLOG) == RATIO)
         else $error("RATIO must be a power of two, at least 2");
      assert (A_D % RATIO == 0 && (1 << AA_W) == A_D)
         else $error("A_D must be a power of two and a multiple of RATIO");
   end

   logic [RA_W-1:0] a_row;
   logic [RLOG-1:0] a_lane;
   logic [RLOG-1:0] a_lane_q;
   logic            a_collide;
   logic [A_W-1:0]  a_lane_q_data [RATIO];

   assign a_row     = a_addr[AA_W-1:RLOG];
   assign a_lane    = a_addr[RLOG-1:0];
   // the wide port wins when both write the same row
   assign a_collide = b_wr && (b_addr == a_row);

   for (genvar l = 0; l < RATIO; l++) begin : g_lane
      logic [A_W-1:0] mem [R_D];
      logic [A_W-1:0] a_q;
      logic [A_W-1:0] b_q;

      always_ff @(posedge clk) begin
         if (b_wr)
            mem[b_addr] <= b_wdata[l*A_W +: A_W];
         if (a_wr && (a_lane == RLOG'(l)) && !a_collide)
            mem[a_row] <= a_wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
         end else begin
            if (a_rd && (a_lane == RLOG'(l))) a_q <= mem[a_row];
            if (b_rd)                         b_q <= mem[b_addr];
         end
      end

      assign a_lane_q_data[l]        = a_q;
      assign b_rdata[l*A_W +: A_W]   = b_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    a_lane_q <= '0;
      else if (a_rd) a_lane_q <= a_lane;
   end

   assign a_rdata = a_lane_q_data[a_lane_q];

   // R5: bank wide-port read data changes only after a wide read
   a_r5_bank_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !b_rd |=> $stable(b_rdata));

endmodule

// File: rtl/opbuf_route.sv
module opbuf_route
   import opbuf_pkg::*;
#(
   parameter  int BANKS = 3,
   parameter  int BK_W  = 2,
   localparam int PHYS  = 2 * BANKS,
   localparam int PI_W  = min1_clog2(PHYS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_i,
   input  logic            en,
   input  logic            we,
   input  logic [BK_W-1:0] bank,
   output logic [PHYS-1:0] rd_vec,
   output logic [PHYS-1:0] wr_vec,
   output logic            valid,
   output logic [PI_W-1:0] idx
);

   op_e op;

   assign op    = decode_op(en, we);
   assign valid = (int'(bank) < BANKS);
   assign idx   = set_i ? PI_W'(int'(bank) + BANKS) : PI_W'(bank);

   for (genvar p = 0; p < PHYS; p++) begin : g_phys
      logic hit;
      assign hit       = valid && (idx == PI_W'(p));
      assign rd_vec[p] = hit && (op == OP_READ);
      assign wr_vec[p] = hit && (op == OP_WRITE);
   end

   // R6: bank code 3 selects no bank
   a_r6_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (en && int'(bank) >= BANKS) |-> ((rd_vec | wr_vec) == '0));
   // R7: at most one bank per port per cycle
   a_r7_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_vec | wr_vec));

endmodule

// File: rtl/opbuf_rdmux.sv
module opbuf_rdmux
   import opbuf_pkg::*;
#(
   parameter  int W    = 32,
   parameter  int N    = 6,
   localparam int PI_W = min1_clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd,
   input  logic            valid,
   input  logic [PI_W-1:0] idx,
   input  logic [W-1:0]    data [N],
   output logic [W-1:0]    dout
);

   logic [PI_W-1:0] idx_q;
   logic            valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         valid_q <= 1'b0;
      end else if (rd) begin
         idx_q   <= idx;
         valid_q <= valid;
      end
   end

   assign dout = valid_q ? data[idx_q] : '0;

   // R5: output holds across cycles with no read on this port
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(dout));
   // R6: a read with a bad bank code returns zero
   a_r6_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !valid) |=> (dout == '0));

endmodule

// File: rtl/opnd_pingpong_buf.sv
module opnd_pingpong_buf
   import opbuf_pkg::*;
#(
   parameter  int BANKS = 3,
   parameter  int N_W   = 32,
   parameter  int N_D   = 64,
   parameter  int RATIO = 2,
   localparam int W_W   = N_W * RATIO,
   localparam int W_D   = N_D / RATIO,
   localparam int NA_W  = $clog2(N_D),
   localparam int WA_W  = $clog2(W_D),
   localparam int BK_W  = min1_clog2(BANKS + 1),
   localparam int PHYS  = 2 * BANKS,
   localparam int PI_W  = min1_clog2(PHYS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            swap_i,
   output logic            sel_o,
   input  logic            n_en,
   input  logic            n_we,
   input  logic [BK_W-1:0] n_bank,
   input  logic [NA_W-1:0] n_addr,
   input  logic [N_W-1:0]  n_wdata,
   output logic [N_W-1:0]  n_rdata,
   input  logic            w_en,
   input  logic            w_we,
   input  logic [BK_W-1:0] w_bank,
   input  logic [WA_W-1:0] w_addr,
   input  logic [W_W-1:0]  w_wdata,
   output logic [W_W-1:0]  w_rdata
);

   initial begin : elab_chk
      assert (BANKS >= 1) else $error("BANKS must be at least 1");
      assert ((1 << BK_W) > BANKS) else $error("bank code needs a spare value");
   end

   logic            sel_q;
   logic [PHYS-1:0] n_rd_vec, n_wr_vec, w_rd_vec, w_wr_vec;
   logic            n_valid, w_valid;
   logic [PI_W-1:0] n_idx, w_idx;
   logic [N_W-1:0]  bank_n_q [PHYS];
   logic [W_W-1:0]  bank_w_q [PHYS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= 1'b0;
      else if (swap_i) sel_q <= ~sel_q;
   end
   assign sel_o = sel_q;

   opbuf_route #(.BANKS(BANKS), .BK_W(BK_W)) u_route_n (
      .clk(clk), .rst_n(rst_n), .set_i(sel_q),
      .en(n_en), .we(n_we), .bank(n_bank),
      .rd_vec(n_rd_vec), .wr_vec(n_wr_vec), .valid(n_valid), .idx(n_idx)
   );

   opbuf_route #(.BANKS(BANKS), .BK_W(BK_W)) u_route_w (
      .clk(clk), .rst_n(rst_n), .set_i(~sel_q),
      .en(w_en), .we(w_we), .bank(w_bank),
      .rd_vec(w_rd_vec), .wr_vec(w_wr_vec), .valid(w_valid), .idx(w_idx)
   );

   for (genvar p = 0; p < PHYS; p++) begin : g_bank
      opbuf_bank #(.A_W(N_W), .A_D(N_D), .RATIO(RATIO)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .a_rd(n_rd_vec[p]), .a_wr(n_wr_vec[p]),
         .a_addr(n_addr), .a_wdata(n_wdata), .a_rdata(bank_n_q[p]),
         .b_rd(w_rd_vec[p]), .b_wr(w_wr_vec[p]),
         .b_addr(w_addr), .b_wdata(w_wdata), .b_rdata(bank_w_q[p])
      );
   end

   opbuf_rdmux #(.W(N_W), .N(PHYS)) u_mux_n (
      .clk(clk), .rst_n(rst_n), .rd(n_en && !n_we),
      .valid(n_valid), .idx(n_idx), .data(bank_n_q), .dout(n_rdata)
   );

   opbuf_rdmux #(.W(W_W), .N(PHYS)) u_mux_w (
      .clk(clk), .rst_n(rst_n), .rd(w_en && !w_we),
      .valid(w_valid), .idx(w_idx), .data(bank_w_q), .dout(w_rdata)
   );

   // R2: selector toggles on a swap strobe and holds otherwise
   a_r2_swap_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      swap_i |=> (sel_o != $past(sel_o)));
   a_r2_no_swap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !swap_i |=> $stable(sel_o));
   // R7: the two ports never reach the same bank in one cycle
   a_r7_sets_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      ((n_rd_vec | n_wr_vec) & (w_rd_vec | w_wr_vec)) == '0);

endmodule

// File: tb/opnd_pingpong_buf_tb.sv
`timescale 1ns/1ps
module opnd_pingpong_buf_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        swap_i = 1'b0;
   logic        sel_o;
   logic        n_en = 1'b0, n_we = 1'b0;
   logic [1:0]  n_bank = '0;
   logic [5:0]  n_addr = '0;
   logic [31:0] n_wdata = '0;
   logic [31:0] n_rdata;
   logic        w_en = 1'b0, w_we = 1'b0;
   logic [1:0]  w_bank = '0;
   logic [4:0]  w_addr = '0;
   logic [63:0] w_wdata = '0;
   logic [63:0] w_rdata;

   int          n_checks = 0;
   int          n_errors = 0;
   bit          done = 1'b0;

   logic [31:0] mdl [6][64];
   logic        sel_m = 1'b0;
   logic [31:0] exp_n = '0;
   logic [63:0] exp_w = '0;

   always #2 clk = ~clk;

   opnd_pingpong_buf u_dut (
      .clk(clk), .rst_n(rst_n), .swap_i(swap_i), .sel_o(sel_o),
      .n_en(n_en), .n_we(n_we), .n_bank(n_bank), .n_addr(n_addr),
      .n_wdata(n_wdata), .n_rdata(n_rdata),
      .w_en(w_en), .w_we(w_we), .w_bank(w_bank), .w_addr(w_addr),
      .w_wdata(w_wdata), .w_rdata(w_rdata)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic int phys(input logic set, input logic [1:0] bank);
      return (set ? 3 : 0) + int'(bank);
   endfunction

   // one clock: inputs already driven; update model and check after the edge
   task automatic cyc(input string req);
      if (n_en && !n_we)
         exp_n = (n_bank < 2'd3) ? mdl[phys(sel_m, n_bank)][n_addr] : '0;
      if (w_en && !w_we)
         exp_w = (w_bank < 2'd3) ?
                 {mdl[phys(!sel_m, w_bank)][{w_addr, 1'b1}],
                  mdl[phys(!sel_m, w_bank)][{w_addr, 1'b0}]} : '0;
      @(negedge clk);
      if (n_en && n_we && n_bank < 2'd3)
         mdl[phys(sel_m, n_bank)][n_addr] = n_wdata;
      if (w_en && w_we && w_bank < 2'd3) begin
         mdl[phys(!sel_m, w_bank)][{w_addr, 1'b0}] = w_wdata[31:0];
         mdl[phys(!sel_m, w_bank)][{w_addr, 1'b1}] = w_wdata[63:32];
      end
      if (swap_i) sel_m = !sel_m;
      chk(req, 64'(n_rdata), 64'(exp_n));
      chk(req, w_rdata, exp_w);
      chk({req, " sel"}, 64'(sel_o), 64'(sel_m));
      n_en = 1'b0; w_en = 1'b0; swap_i = 1'b0;
   endtask

   initial begin : watchdog
      #(200000 * 4);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h1a2b3c4d));
      for (int p = 0; p < 6; p++)
         for (int a = 0; a < 64; a++) mdl[p][a] = '0;
      repeat (3) @(negedge clk);
      // R1: reset values while reset is held
      chk("R1", 64'(n_rdata), 64'd0);
      chk("R1", w_rdata, 64'd0);
      chk("R1", 64'(sel_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 64'(sel_o), 64'd0);

      // R7/R8: narrow port fills set 0 while wide port fills set 1
      for (int b = 0; b < 3; b++)
         for (int a = 0; a < 64; a++) begin
            n_en = 1; n_we = 1; n_bank = 2'(b); n_addr = 6'(a);
            n_wdata = {8'hA0 + 8'(b), 8'(a), 16'($urandom)};
            if (a < 32) begin
               w_en = 1; w_we = 1; w_bank = 2'(b); w_addr = 5'(a);
               w_wdata = {8'hB0 + 8'(b), 8'(a), 16'($urandom), 32'($urandom)};
            end
            cyc("R7");
         end
      // R3/R8: read back each set through its own port
      for (int b = 0; b < 3; b++)
         for (int a = 0; a < 64; a++) begin
            n_en = 1; n_we = 0; n_bank = 2'(b); n_addr = 6'(a);
            if (a < 32) begin
               w_en = 1; w_we = 0; w_bank = 2'(b); w_addr = 5'(a);
            end
            cyc("R8");
         end
      // R2: swap, then cross-read through the opposite port (R4)
      swap_i = 1; cyc("R2");
      for (int b = 0; b < 3; b++)
         for (int a = 0; a < 64; a++) begin
            n_en = 1; n_we = 0; n_bank = 2'(b); n_addr = 6'(a);
            if (a < 32) begin
               w_en = 1; w_we = 0; w_bank = 2'(b); w_addr = 5'(a);
            end
            cyc("R4");
         end
      // R2: read in the same cycle as a swap uses the old set
      n_en = 1; n_we = 0; n_bank = 2'd1; n_addr = 6'd7;
      w_en = 1; w_we = 0; w_bank = 2'd2; w_addr = 5'd9;
      swap_i = 1; cyc("R2");
      n_en = 1; n_we = 0; n_bank = 2'd1; n_addr = 6'd7; cyc("R2");
      // R6: bad bank code write changes nothing, read returns zero
      n_en = 1; n_we = 1; n_bank = 2'd3; n_addr = 6'd5; n_wdata = 32'hDEAD_BEEF; cyc("R6");
      w_en = 1; w_we = 1; w_bank = 2'd3; w_addr = 5'd2; w_wdata = 64'hFFFF_FFFF_FFFF_FFFF; cyc("R6");
      n_en = 1; n_we = 0; n_bank = 2'd3; n_addr = 6'd5; cyc("R6");
      w_en = 1; w_we = 0; w_bank = 2'd3; w_addr = 5'd2; cyc("R6");
      for (int b = 0; b < 3; b++) begin
         n_en = 1; n_we = 0; n_bank = 2'(b); n_addr = 6'd5;
         w_en = 1; w_we = 0; w_bank = 2'(b); w_addr = 5'd2;
         cyc("R6");
      end
      // R5: read data holds through idle, writes and other-port traffic
      n_en = 1; n_we = 0; n_bank = 2'd0; n_addr = 6'd10; cyc("R5");
      cyc("R5");
      n_en = 1; n_we = 1; n_bank = 2'd0; n_addr = 6'd10; n_wdata = 32'h1234_5678; cyc("R5");
      w_en = 1; w_we = 0; w_bank = 2'd0; w_addr = 5'd1; cyc("R5");
      n_en = 1; n_we = 0; n_bank = 2'd0; n_addr = 6'd10; cyc("R3");

      // random mix of both ports and swaps
      for (int i = 0; i < 6000; i++) begin
         n_en = 1'($urandom); n_we = 1'($urandom);
         n_bank = 2'($urandom); n_addr = 6'($urandom); n_wdata = $urandom;
         w_en = 1'($urandom); w_we = 1'($urandom);
         w_bank = 2'($urandom); w_addr = 5'($urandom);
         w_wdata = {$urandom, $urandom};
         swap_i = (($urandom % 8) == 0);
         cyc("R7");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule